// File: doc/BRIEF.md
# Hall Sensor Fault Detector

This block supervises the three position sensors of a six-step brushless motor drive. Every clock it takes the present three-bit Hall code and reports the matching commutation sector. Codes that never occur on a healthy motor (all zeros or all ones) raise a pattern-error flag.

Each sensor line has its own edge detector. It reacts to both polarities and opens a window of programmable length after every change. A healthy motor changes one sensor at a time, with long gaps between changes. If the windows of two different sensors are open in the same cycle, two changes happened too close together, and a sequence-error flag is raised. Both flags are sticky: they stay set until software or a supervisor pulses the clear input, so a single-cycle glitch is never lost. A fault that is still present when clear arrives keeps its flag set.

The Hall inputs must already be synchronized to `clk`. Bit 2 of `hall_in` is the first sensor, bit 1 the second and bit 0 the third.

Internally, a two-state sampler (PRIME, RUN) takes the first code after reset as its reference. Three pulse machines (IDLE, HOLD) produce the per-sensor windows. Two flag machines (CLEAR, SET) hold the errors. The transitions are:
- Sampler: PRIME->RUN on the first clock after reset.
- Pulse machine: IDLE->HOLD on an edge. HOLD->HOLD on an edge, which reloads the count, or while counting down. HOLD->IDLE when the count expires.
- Flag machine: CLEAR->SET when its condition is true. SET->CLEAR when clear is high and the condition is false.

Top module: `hall_fault_detector`

## Requirements
- R1: `sector` is registered one clock after the code is sampled. Codes map as 100->1, 101->2, 001->3, 011->4, 010->5, 110->6 (bit order first, second, third sensor). Codes 000 and 111 give 0.
- R2: A sampled code of 000 or 111 sets `pat_err` at that same clock edge.
- R3: Let L be the effective pulse length. A change on one sensor and a later change on a different sensor, sampled at most L clocks apart, set `seq_err` at the edge that samples the second change. Changes sampled L+1 or more clocks apart do not set it.
- R4: Changes on two or more sensors sampled at the same clock edge set `seq_err` at that edge.
- R5: `pulse_len` gives L in clock cycles. A value of 0 selects the default length of 4.
- R6: Both flags stay set until `err_clr` is high at a clock edge where their condition is absent. At that edge the flag clears.
- R7: If `err_clr` is high at an edge where the flag's condition is present, the flag is set (or stays set) after that edge.
- R8: A further change on the same sensor while its window is open restarts that window at full length L.
- R9: The first code sampled after reset is taken as the reference and produces no edge, whatever its value.
- R10: During and right after reset, `pat_err`, `seq_err` and `sector` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hall_in | input | 3 | Synchronized Hall code: bit 2 first sensor, bit 0 third |
| err_clr | input | 1 | Clears both sticky flags when their condition is absent |
| pulse_len | input | PW (8) | Edge window length in clocks; 0 selects 4 |
| pat_err | output | 1 | Sticky illegal-code flag |
| seq_err | output | 1 | Sticky near-simultaneous-edge flag |
| sector | output | 3 | Current sector 1..6, 0 for an illegal code |

## Verification
A pulse counter that reloads wrongly, or that expires one cycle early or late, moves the boundary between a clean commutation and a flagged one. This shows up as `seq_err` appearing, or failing to appear, at the exact edge that samples the second change, which the bench probes at L and L+1 cycles of separation. A flag machine stuck in the wrong state shows up at the very next clock: the flag either survives a clear given during a quiet cycle, or drops while its fault is still present. A sampler that never leaves its priming state suppresses every edge, and no sequence fault is ever reported.

// File: rtl/hall_pkg.sv
package hall_pkg;

    localparam int NUM_HALL = 3;

    typedef enum logic [0:0] {
        SMP_PRIME,
        SMP_RUN
    } smp_state_e;

    typedef enum logic [0:0] {
        PLS_IDLE,
        PLS_HOLD
    } pls_state_e;

    typedef enum logic [0:0] {
        FLAG_CLEAR,
        FLAG_SET
    } flag_state_e;

    function automatic logic [2:0] code_to_sector(input logic [2:0] code);
        logic [2:0] s;
        unique case (code)
            3'b100:  s = 3'd1;
            3'b101:  s = 3'd2;
            3'b001:  s = 3'd3;
            3'b011:  s = 3'd4;
            3'b010:  s = 3'd5;
            3'b110:  s = 3'd6;
            default: s = 3'd0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/hall_sampler.sv
module hall_sampler
    import hall_pkg::*;
#(
    parameter int W = NUM_HALL
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] hall_in,
    output logic [W-1:0] hall_prev,
    output logic         running
);

    smp_state_e state_q, state_d;
    logic [W-1:0] prev_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SMP_PRIME;
            prev_q  <= '0;
        end else begin
            state_q <= state_d;
            prev_q  <= hall_in;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        running = 1'b0;
        unique case (state_q)
            SMP_PRIME: state_d = SMP_RUN;
            SMP_RUN:   running = 1'b1;
            default:   state_d = SMP_PRIME;
        endcase
    end

    assign hall_prev = prev_q;

endmodule

// File: rtl/hall_edge_pulse.sv
module hall_edge_pulse
    import hall_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          running,
    input  logic          din,
    input  logic          din_prev,
    input  logic [CW-1:0] len,
    output logic          pulse
);

    pls_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          edge_now;

    assign edge_now = running & (din ^ din_prev);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PLS_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state, count and pulse output
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        pulse   = edge_now;
        unique case (state_q)
            PLS_IDLE: begin
                if (edge_now) begin
                    state_d = PLS_HOLD;
                    cnt_d   = len;
                end
            end
            PLS_HOLD: begin
                pulse = 1'b1;
                if (edge_now) begin
                    cnt_d = len;
                end else if (cnt_q <= 1) begin
                    state_d = PLS_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: begin
                state_d = PLS_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

endmodule

// File: rtl/hall_flag_fsm.sv
module hall_flag_fsm
    import hall_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic raise,
    input  logic clr,
    output logic flag
);

    flag_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLAG_CLEAR;
        else        state_q <= state_d;
    end

    // next state and output
    always_comb begin
        state_d = state_q;
        flag    = 1'b0;
        unique case (state_q)
            FLAG_CLEAR: if (raise) state_d = FLAG_SET;
            FLAG_SET: begin
                flag = 1'b1;
                if (clr && !raise) state_d = FLAG_CLEAR;
            end
            default: state_d = FLAG_CLEAR;
        endcase
    end

endmodule

// File: rtl/hall_fault_detector.sv
module hall_fault_detector
    import hall_pkg::*;
#(
    parameter int PW      = 8,
    parameter int DEF_LEN = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    hall_in,
    input  logic          err_clr,
    input  logic [PW-1:0] pulse_len,
    output logic          pat_err,
    output logic          seq_err,
    output logic [2:0]    sector
);

    localparam logic [PW-1:0] DEF_LEN_V = PW'(DEF_LEN);

    logic [NUM_HALL-1:0] hall_prev;
    logic                running;
    logic [NUM_HALL-1:0] pulse_act;
    logic [PW-1:0]       eff_len;
    logic                seq_cond;
    logic                pat_cond;
    logic [2:0]          sector_q;

    assign eff_len = (pulse_len == '0) ? DEF_LEN_V : pulse_len;

    hall_sampler #(.W(NUM_HALL)) u_smp (
        .clk       (clk),
        .rst_n     (rst_n),
        .hall_in   (hall_in),
        .hall_prev (hall_prev),
        .running   (running)
    );

    for (genvar g = 0; g < NUM_HALL; g++) begin : g_ch
        hall_edge_pulse #(.CW(PW)) u_pls (
            .clk      (clk),
            .rst_n    (rst_n),
            .running  (running),
            .din      (hall_in[g]),
            .din_prev (hall_prev[g]),
            .len      (eff_len),
            .pulse    (pulse_act[g])
        );
    end

    // any pair of open windows is a sequence fault
    always_comb begin
        seq_cond = 1'b0;
        for (int i = 0; i < NUM_HALL; i++) begin
            for (int j = i + 1; j < NUM_HALL; j++) begin
                seq_cond = seq_cond | (pulse_act[i] & pulse_act[j]);
            end
        end
    end

    assign pat_cond = (hall_in == 3'b000) || (hall_in == 3'b111);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sector_q <= 3'd0;
        else        sector_q <= code_to_sector(hall_in);
    end
    assign sector = sector_q;

    hall_flag_fsm u_pat (
        .clk   (clk),
        .rst_n (rst_n),
        .raise (pat_cond),
        .clr   (err_clr),
        .flag  (pat_err)
    );

    hall_flag_fsm u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .raise (seq_cond),
        .clr   (err_clr),
        .flag  (seq_err)
    );

endmodule

// File: rtl/hall_fault_checker.sv
module hall_fault_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] hall_in,
    input logic       err_clr,
    input logic       pat_err,
    input logic       seq_err,
    input logic [2:0] sector,
    input logic [2:0] pulse_act
);

    logic bad_code;
    assign bad_code = (hall_in == 3'b000) || (hall_in == 3'b111);

    AST_SECTOR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        sector <= 3'd6); // R1
    AST_SECTOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bad_code |=> (sector == 3'd0)); // R1
    AST_PAT_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        bad_code |=> pat_err); // R2
    AST_SEQ_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(pulse_act) >= 2) |=> seq_err); // R3
    AST_PAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (pat_err && !err_clr) |=> pat_err); // R6
    AST_SEQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_err && !err_clr) |=> seq_err); // R6
    AST_PAT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && !bad_code) |=> !pat_err); // R6
    AST_CLR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && bad_code) |=> pat_err); // R7

endmodule

bind hall_fault_detector hall_fault_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hall_in   (hall_in),
    .err_clr   (err_clr),
    .pat_err   (pat_err),
    .seq_err   (seq_err),
    .sector    (sector),
    .pulse_act (pulse_act)
);

// File: tb/tb_hall_fault_detector.sv
module tb_hall_fault_detector;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] hall_in = 3'b011;
    logic       err_clr = 1'b0;
    logic [7:0] pulse_len = 8'd0;
    logic       pat_err, seq_err;
    logic [2:0] sector;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    hall_fault_detector dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .hall_in   (hall_in),
        .err_clr   (err_clr),
        .pulse_len (pulse_len),
        .pat_err   (pat_err),
        .seq_err   (seq_err),
        .sector    (sector)
    );

    typedef struct {
        logic       pat;
        logic       seq;
        logic [2:0] sec;
        string      tag;
    } exp_t;

    exp_t sb[$];

    // sector numbering as stated in R1
    function automatic logic [2:0] ref_sector(input logic [2:0] c);
        case (c)
            3'b100: return 3'd1;
            3'b101: return 3'd2;
            3'b001: return 3'd3;
            3'b011: return 3'd4;
            3'b010: return 3'd5;
            3'b110: return 3'd6;
            default: return 3'd0;
        endcase
    endfunction

    task automatic check(input logic [2:0] act, input logic [2:0] exp, input string what);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    // driver: one clock of stimulus, expectation queued for the monitor
    task automatic go(input logic [2:0] h, input logic clr, input int n,
                      input logic ep, input logic es, input string tag);
        for (int k = 0; k < n; k++) begin
            exp_t e;
            @(negedge clk);
            hall_in = h;
            err_clr = clr;
            e.pat = ep;
            e.seq = es;
            e.sec = ref_sector(h);
            e.tag = tag;
            sb.push_back(e);
        end
    endtask

    // monitor: compare after each active edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check({2'b0, pat_err}, {2'b0, e.pat}, {e.tag, " pat_err"});
                check({2'b0, seq_err}, {2'b0, e.seq}, {e.tag, " seq_err"});
                check(sector, e.sec, {e.tag, " sector"});
            end
        end
    end

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R10: reset state while reset is held
        repeat (3) @(negedge clk);
        check({2'b0, pat_err}, 3'd0, "R10 reset pat_err");
        check({2'b0, seq_err}, 3'd0, "R10 reset seq_err");
        check(sector, 3'd0, "R10 reset sector");
        rst_n = 1'b1;

        // R9: two bits differ from the reset value, still no edge
        go(3'b011, 0, 3, 0, 0, "R9 prime");
        // R1, R3: clean rotation, second change 5 clocks after first
        go(3'b010, 0, 5, 0, 0, "R1 R3 step");
        go(3'b110, 0, 6, 0, 0, "R3 gap L+1");
        // R3: second change exactly L=4 clocks later
        go(3'b100, 0, 4, 0, 0, "R1 step");
        go(3'b101, 0, 1, 0, 1, "R3 gap L");
        go(3'b101, 0, 3, 0, 1, "R6 seq sticky");
        go(3'b101, 1, 1, 0, 0, "R6 seq clear");
        go(3'b101, 0, 4, 0, 0, "R6 stays clear");
        // R4, R7: two sensors at once while clear is high
        go(3'b011, 1, 1, 0, 1, "R4 R7 simultaneous");
        go(3'b011, 0, 6, 0, 1, "R6 seq sticky");
        go(3'b011, 1, 1, 0, 0, "R6 seq clear");
        // R8: third sensor toggles twice, restart reaches the later change
        go(3'b010, 0, 2, 0, 0, "R8 first toggle");
        go(3'b011, 0, 4, 0, 0, "R8 restart");
        go(3'b001, 0, 1, 0, 1, "R8 overlap after restart");
        go(3'b001, 0, 5, 0, 1, "R6 seq sticky");
        go(3'b001, 1, 1, 0, 0, "R6 seq clear");
        // R5: programmed length 2
        @(negedge clk);
        pulse_len = 8'd2;
        sb.push_back('{pat: 1'b0, seq: 1'b0, sec: 3'd3, tag: "R5 hold"});
        go(3'b101, 0, 3, 0, 0, "R5 step");
        go(3'b100, 0, 5, 0, 0, "R5 gap 3 clean");
        go(3'b110, 0, 2, 0, 0, "R5 step");
        go(3'b010, 0, 1, 0, 1, "R5 gap 2 fault");
        go(3'b010, 0, 3, 0, 1, "R6 seq sticky");
        go(3'b010, 1, 1, 0, 0, "R6 seq clear");
        // R2: illegal all-zero code
        go(3'b000, 0, 3, 1, 0, "R2 code 000");
        go(3'b010, 0, 3, 1, 0, "R6 pat sticky");
        go(3'b010, 1, 1, 0, 0, "R6 pat clear");
        go(3'b110, 0, 4, 0, 0, "R1 step");
        // R2, R7: illegal all-one code, clear while still present
        go(3'b111, 0, 1, 1, 0, "R2 code 111");
        go(3'b111, 1, 2, 1, 0, "R7 clear loses");
        go(3'b110, 1, 1, 0, 0, "R6 pat clear");

        go(3'b110, 0, 2, 0, 0, "R1 idle");
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule